// File: doc/BRIEF.md
# Byte-Capacity SPI Data Queue with Level Thresholds

This block is the data queue that sits between a bus-side register port and the shift engine of an SPI controller, for one transfer direction. Its storage is a fixed 256 bytes, and the entry width can be set to 8, 16 or 32 bits, so the queue holds 256, 128 or 64 entries. Data enters through a push port and leaves through a pop port, and each port uses a valid/ready handshake.

A two-bit operation command controls the queue. One bit empties the queue and latches a new entry width. The other bit lets data move through the ports. The queue reports its fill level, full and empty in a packed status word. It gives a one-cycle pulse when the level rises to a programmable threshold, and one-cycle error pulses when a push or a pop is refused. Three level-check flags compare the fill level against three programmable points. Interrupt logic or pacing logic next to the queue can use these flags.

Top module: `spi_fifo_level`

## Requirements
- R1: After the reset input is released, the status word reads 0x200 (empty set, full clear, level 0), both pushReady and popValid are low, and the active entry width is 8 bits.
- R2: A command write with bit 1 set enables the ports. A command write of 0 stops the queue: pushReady and popValid go low, push and pop requests are ignored without error pulses, and the stored data and level are kept until the queue is started again.
- R3: A command write with bit 0 set empties the queue in the next cycle and loads the active entry width from widthSel. A change of widthSel without this command has no effect on stored entries or on new entries.
- R4: widthSel 0, 1 and 2 give 256, 128 and 64 entries, and code 3 is treated as 2. When the level equals the entry count, full is set and pushReady is low.
- R5: The status word holds the level in entries in bits 7:0, full in bit 8 and empty in bit 9. The level field saturates at 255, so 256 byte entries read as 255 with full set.
- R6: Entries come out in push order. An entry keeps the low 8, 16 or 32 bits of pushData for the active width. popData shows the head entry, zero-extended to 32 bits.
- R7: A push request while the queue is started and full is dropped. overflowErr is high for exactly the one cycle after the request, and the level does not change.
- R8: A pop request while the queue is started and empty is dropped. underflowErr is high for exactly the one cycle after the request.
- R9: thrHit is high for one cycle, in the same cycle that the level first shows a value equal to or above threshold after it was below. It stays low while the level remains at or above threshold.
- R10: stopHit, lowHit and highHit are high while the level is equal to or above stopChk, lowChk and highChk respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opWrEn | input | 1 | Command write strobe |
| opData | input | 2 | Command: bit 0 empty and latch width, bit 1 run |
| widthSel | input | 2 | Requested entry width: 0 byte, 1 half word, 2 or 3 word |
| threshold | input | 8 | Threshold level in entries |
| stopChk | input | 6 | First level-check point |
| lowChk | input | 6 | Second level-check point |
| highChk | input | 6 | Third level-check point |
| pushValid | input | 1 | Push request |
| pushReady | output | 1 | Queue can accept a push |
| pushData | input | 32 | Push data |
| popValid | output | 1 | Queue holds an entry to deliver |
| popReady | input | 1 | Pop request |
| popData | output | 32 | Head entry, zero-extended |
| status | output | 10 | {empty, full, level[7:0]} |
| thrHit | output | 1 | Threshold-reached pulse |
| overflowErr | output | 1 | Refused-push pulse |
| underflowErr | output | 1 | Refused-pop pulse |
| stopHit | output | 1 | Level at or above stopChk |
| lowHit | output | 1 | Level at or above lowChk |
| highHit | output | 1 | Level at or above highChk |

## Verification
The assertions check a set of properties on every cycle:
- the byte count never exceeds the capacity;
- the empty command clears the count;
- a stopped queue keeps its count;
- the threshold pulse never lasts two cycles;
- error pulses follow only a full or empty state;
- full and empty are never set together.

Some behaviour can only be shown by the bench scenarios:
- the data values and their order for each entry width;
- the entry count for each width, including level saturation at 256 byte entries;
- that the width setting is held until the empty command;
- the exact cycle of the threshold pulse after a level rise that comes from a pop followed by a push.

// File: rtl/spififo_pkg.sv
package spififo_pkg;
  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_HALF = 2'd1,
    WID_WORD = 2'd2
  } widthSel_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoStrobe_t;
endpackage

// File: rtl/spififo_datapath.sv
module spififo_datapath
  import spififo_pkg::*;
#(
  parameter int CAP_BYTES = 256,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  fifoStrobe_t                    strobe,
  input  logic [1:0]                     activeWidth,
  input  logic [DATA_W-1:0]              pushData,
  output logic [DATA_W-1:0]              popData,
  output logic [$clog2(CAP_BYTES):0]     byteCount
);
  localparam int PTR_W = $clog2(CAP_BYTES);
  localparam int CNT_W = PTR_W + 1;
  localparam int LANES = DATA_W / 8;

  logic [7:0]       mem [CAP_BYTES];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] bytesPer;

  assign bytesPer = CNT_W'(1) << activeWidth;

  // byte storage, entry spread over consecutive bytes, low byte first
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      for (int i = 0; i < LANES; i++) begin
        if (CNT_W'(i) < bytesPer) mem[wrPtr + PTR_W'(i)] <= pushData[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      byteCount <= '0;
    end else if (strobe.clear) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      byteCount <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + PTR_W'(bytesPer);
      if (strobe.pop)  rdPtr <= rdPtr + PTR_W'(bytesPer);
      byteCount <= byteCount + (strobe.push ? bytesPer : '0) - (strobe.pop ? bytesPer : '0);
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      assign popData[8*g +: 8] = (CNT_W'(g) < bytesPer) ? mem[rdPtr + PTR_W'(g)] : 8'h00;
    end
  endgenerate

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= CNT_W'(CAP_BYTES)) else $error("byte count above capacity");

  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> byteCount == '0) else $error("empty command left data");
endmodule

// File: rtl/spififo_ctrl.sv
module spififo_ctrl
  import spififo_pkg::*;
#(
  parameter int CAP_BYTES = 256,
  parameter int LVL_W     = 8,
  parameter int CHK_W     = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       opWrEn,
  input  logic [1:0]                 opData,
  input  logic [1:0]                 widthSel,
  input  logic [LVL_W-1:0]           threshold,
  input  logic [CHK_W-1:0]           stopChk,
  input  logic [CHK_W-1:0]           lowChk,
  input  logic [CHK_W-1:0]           highChk,
  input  logic                       pushValid,
  input  logic                       popReady,
  input  logic [$clog2(CAP_BYTES):0] byteCount,
  output fifoStrobe_t                strobe,
  output logic [1:0]                 activeWidth,
  output logic                       pushReady,
  output logic                       popValid,
  output logic [LVL_W+1:0]           status,
  output logic                       thrHit,
  output logic                       overflowErr,
  output logic                       underflowErr,
  output logic                       stopHit,
  output logic                       lowHit,
  output logic                       highHit
);
  localparam int CNT_W   = $clog2(CAP_BYTES) + 1;
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  logic             started, clearOp, fullNow, emptyNow;
  logic [CNT_W-1:0] entryCount, capEntries, nextEntries;
  logic [LVL_W-1:0] levelSat;
  logic [1:0]       widthClean;

  assign widthClean = (widthSel == 2'd3) ? WID_WORD : widthSel;
  assign clearOp    = opWrEn & opData[0];
  assign entryCount = byteCount >> activeWidth;
  assign capEntries = CNT_W'(CAP_BYTES) >> activeWidth;
  assign fullNow    = entryCount == capEntries;
  assign emptyNow   = byteCount == '0;

  assign pushReady    = started & ~fullNow & ~clearOp;
  assign popValid     = started & ~emptyNow & ~clearOp;
  assign strobe.push  = pushValid & pushReady;
  assign strobe.pop   = popReady & popValid;
  assign strobe.clear = clearOp;

  assign nextEntries = entryCount + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
  assign levelSat    = (entryCount > CNT_W'(LVL_MAX)) ? LVL_W'(LVL_MAX) : entryCount[LVL_W-1:0];
  assign status      = {emptyNow, fullNow, levelSat};

  assign stopHit = levelSat >= LVL_W'(stopChk);
  assign lowHit  = levelSat >= LVL_W'(lowChk);
  assign highHit = levelSat >= LVL_W'(highChk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started      <= 1'b0;
      activeWidth  <= WID_BYTE;
      thrHit       <= 1'b0;
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      if (opWrEn)  started     <= opData[1];
      if (clearOp) activeWidth <= widthClean;
      thrHit       <= ~clearOp && (entryCount < CNT_W'(threshold))
                      && (nextEntries >= CNT_W'(threshold));
      overflowErr  <= pushValid & started & fullNow & ~clearOp;
      underflowErr <= popReady & started & emptyNow & ~clearOp;
    end
  end

  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!started && !clearOp) |=> $stable(byteCount)) else $error("stopped queue moved");

  assert_thr_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    thrHit |=> !thrHit) else $error("threshold pulse too long");

  assert_ovf_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |-> $past(fullNow)) else $error("overflow without full");

  assert_und_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |-> $past(emptyNow)) else $error("underflow without empty");
endmodule

// File: rtl/spi_fifo_level.sv
module spi_fifo_level
  import spififo_pkg::*;
#(
  parameter int CAP_BYTES = 256,
  parameter int DATA_W    = 32,
  parameter int LVL_W     = 8,
  parameter int CHK_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opWrEn,
  input  logic [1:0]        opData,
  input  logic [1:0]        widthSel,
  input  logic [LVL_W-1:0]  threshold,
  input  logic [CHK_W-1:0]  stopChk,
  input  logic [CHK_W-1:0]  lowChk,
  input  logic [CHK_W-1:0]  highChk,
  input  logic              pushValid,
  output logic              pushReady,
  input  logic [DATA_W-1:0] pushData,
  output logic              popValid,
  input  logic              popReady,
  output logic [DATA_W-1:0] popData,
  output logic [LVL_W+1:0]  status,
  output logic              thrHit,
  output logic              overflowErr,
  output logic              underflowErr,
  output logic              stopHit,
  output logic              lowHit,
  output logic              highHit
);
  localparam int CNT_W = $clog2(CAP_BYTES) + 1;

  fifoStrobe_t      strobe;
  logic [1:0]       activeWidth;
  logic [CNT_W-1:0] byteCount;

  spififo_ctrl #(.CAP_BYTES(CAP_BYTES), .LVL_W(LVL_W), .CHK_W(CHK_W)) i_ctrl (
    .clk, .rstN, .opWrEn, .opData, .widthSel, .threshold, .stopChk, .lowChk, .highChk,
    .pushValid, .popReady, .byteCount, .strobe, .activeWidth, .pushReady, .popValid,
    .status, .thrHit, .overflowErr, .underflowErr, .stopHit, .lowHit, .highHit
  );

  spififo_datapath #(.CAP_BYTES(CAP_BYTES), .DATA_W(DATA_W)) i_data (
    .clk, .rstN, .strobe, .activeWidth, .pushData, .popData, .byteCount
  );

  assert_full_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(status[LVL_W+1:LVL_W])) else $error("full and empty together");
endmodule

// File: tb/test_spi_fifo_level.sv
`timescale 1ns/1ps
module test_spi_fifo_level;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opWrEn = 1'b0;
  logic [1:0]  opData = '0;
  logic [1:0]  widthSel = '0;
  logic [7:0]  threshold = '0;
  logic [5:0]  stopChk = '0, lowChk = '0, highChk = '0;
  logic        pushValid = 1'b0, popReady = 1'b0;
  logic [31:0] pushData = '0;
  logic        pushReady, popValid, thrHit, overflowErr, underflowErr;
  logic        stopHit, lowHit, highHit;
  logic [31:0] popData;
  logic [9:0]  status;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  spi_fifo_level i_spi_fifo_level (
    .clk, .rstN, .opWrEn, .opData, .widthSel, .threshold, .stopChk, .lowChk, .highChk,
    .pushValid, .pushReady, .pushData, .popValid, .popReady, .popData, .status,
    .thrHit, .overflowErr, .underflowErr, .stopHit, .lowHit, .highHit
  );

  // {width code, entries to push}
  localparam logic [10:0] VECS [0:5] = '{
    {2'd0, 9'd256}, {2'd1, 9'd128}, {2'd2, 9'd64},
    {2'd0, 9'd5},   {2'd1, 9'd3},   {2'd3, 9'd40}
  };

  function automatic logic [31:0] pat(int k, int v);
    return {8'(k * 7 + v), 8'(k + 8'h40), 8'(k ^ 8'h5A), 8'(k + v)};
  endfunction

  function automatic logic [31:0] wmask(int w);
    return (w == 0) ? 32'h0000_00FF : (w == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic int capOf(int w);
    return (w == 0) ? 256 : (w == 1) ? 128 : 64;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic opWrite(input logic [1:0] d);
    @(negedge clk); opWrEn = 1'b1; opData = d;
    @(negedge clk); opWrEn = 1'b0; opData = '0;
  endtask

  // pushes n entries back to back; thrHit expected only after push number pulseAt
  task automatic pushStream(input int n, input int v, input int pulseAt);
    @(negedge clk); pushValid = 1'b1; pushData = pat(0, v);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      check(thrHit == (k == pulseAt), "R9 threshold pulse", 32'(thrHit), 32'(k == pulseAt));
      if (k < n) pushData = pat(k, v);
      else pushValid = 1'b0;
    end
  endtask

  task automatic popStream(input int n, input int v, input int w);
    @(negedge clk); popReady = 1'b1;
    for (int k = 0; k < n; k++) begin
      check(popValid && popData == (pat(k, v) & wmask(w)), "R6 pop data",
            popData, pat(k, v) & wmask(w));
      @(negedge clk);
    end
    popReady = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(status == 10'h200, "R1 status after reset", 32'(status), 32'h200);
    check(!pushReady && !popValid, "R1 ports idle", 32'({pushReady, popValid}), 0);

    // table walk: R4 capacity, R5 level and flags, R6 data order
    for (int t = 0; t < 6; t++) begin
      int w, wEff, n, lvl;
      w    = int'(VECS[t][10:9]);
      n    = int'(VECS[t][8:0]);
      wEff = (w == 3) ? 2 : w;
      lvl  = (n > 255) ? 255 : n;
      widthSel = 2'(w);
      opWrite(2'b01);
      opWrite(2'b10);
      pushStream(n, t, 0);
      check(status[7:0] == 8'(lvl), "R5 level field", 32'(status[7:0]), 32'(lvl));
      check(status[8] == (n == capOf(wEff)), "R4 full flag", 32'(status[8]), 32'(n == capOf(wEff)));
      check(pushReady == (n != capOf(wEff)), "R4 push ready", 32'(pushReady), 32'(n != capOf(wEff)));
      popStream(n, t, wEff);
      check(status == 10'h200, "R5 empty after drain", 32'(status), 32'h200);
    end

    // R7 overflow on a full 64-entry queue
    widthSel = 2'd2;
    opWrite(2'b11);
    pushStream(64, 9, 0);
    @(negedge clk); pushValid = 1'b1; pushData = 32'hDEAD_BEEF;
    @(negedge clk); pushValid = 1'b0;
    check(overflowErr == 1'b1, "R7 overflow pulse", 32'(overflowErr), 1);
    check(status[7:0] == 8'd64, "R7 level unchanged", 32'(status[7:0]), 64);
    @(negedge clk);
    check(overflowErr == 1'b0, "R7 pulse one cycle", 32'(overflowErr), 0);
    popStream(1, 9, 2);

    // R8 underflow on an empty queue
    opWrite(2'b11);
    @(negedge clk); popReady = 1'b1;
    @(negedge clk); popReady = 1'b0;
    check(underflowErr == 1'b1, "R8 underflow pulse", 32'(underflowErr), 1);
    @(negedge clk);
    check(underflowErr == 1'b0, "R8 pulse one cycle", 32'(underflowErr), 0);

    // R2 stop keeps data and refuses traffic
    pushStream(3, 2, 0);
    opWrite(2'b00);
    check(!pushReady && !popValid, "R2 stopped ports", 32'({pushReady, popValid}), 0);
    @(negedge clk); pushValid = 1'b1; popReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(status[7:0] == 8'd3, "R2 level held", 32'(status[7:0]), 3);
    check(!overflowErr && !underflowErr, "R2 no error while stopped",
          32'({overflowErr, underflowErr}), 0);
    pushValid = 1'b0; popReady = 1'b0;
    opWrite(2'b10);
    popStream(3, 2, 2);

    // R3 width held until empty command
    widthSel = 2'd1;
    pushStream(1, 4, 0);
    popStream(1, 4, 2);
    pushStream(4, 5, 0);
    opWrite(2'b11);
    check(status == 10'h200, "R3 empty command", 32'(status), 32'h200);
    pushStream(1, 6, 0);
    popStream(1, 6, 1);

    // R9 threshold crossing, including a rise after pops
    widthSel = 2'd0;
    threshold = 8'd5;
    opWrite(2'b11);
    pushStream(7, 7, 5);
    popStream(3, 7, 0);
    check(thrHit == 1'b0, "R9 no pulse on falling level", 32'(thrHit), 0);
    pushStream(1, 8, 1);

    // R10 level-check flags
    stopChk = 6'd2; lowChk = 6'd10; highChk = 6'd20;
    opWrite(2'b11);
    check({stopHit, lowHit, highHit} == 3'b000, "R10 flags when empty",
          32'({stopHit, lowHit, highHit}), 0);
    pushStream(10, 1, 5);
    check({stopHit, lowHit, highHit} == 3'b110, "R10 flags at ten",
          32'({stopHit, lowHit, highHit}), 32'b110);
    pushStream(10, 2, 0);
    check({stopHit, lowHit, highHit} == 3'b111, "R10 flags at twenty",
          32'({stopHit, lowHit, highHit}), 32'b111);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule